// File: doc/BRIEF.md
# Memory-Mapped Real-Time Clock Core

This block keeps wall-clock time for a system from a slow 32 kHz reference strobe. A fractional accumulator turns the reference ticks into milliseconds, so 32768 ticks make exactly one second. Milliseconds run from 0 to 999, and each wrap increments a 32-bit seconds counter. On every eighth reference tick the running time is moved into registers that the bus can see. A busy flag is held for a short copy window while that happens, and any bus write attempted inside the window is dropped.

Software reads time by reading milliseconds first. That read captures the visible seconds into a shadow register, so reading the shadow register next gives a seconds/milliseconds pair from the same instant. There are two seconds alarms and one milliseconds alarm. Each one sets its own bit in an event register, and software clears a bit by writing 1 to it. An enable register decides which events drive the single level-sensitive interrupt line.

Top module: `rtc_core`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Bit 0 of the busy register (offset 0x004) reads 1 for COPY_CYCLES clocks, starting after every eighth reference tick. At the end of that window the seconds (0x008) and milliseconds (0x010) registers take the running time. Between windows they keep the last value copied.
- R3: A read of milliseconds (0x010) loads the shadow register (0x00C) with the seconds value visible in the same access. The shadow register does not change on any other access.
- R4: N ticks after a seconds write, the running milliseconds value is floor(N*1000/32768) mod 1000. It never reaches 1000.
- R5: When milliseconds wraps from 999 to 0, seconds increments by one.
- R6: Every bus write that arrives while busy is 1 is ignored. The same write with busy at 0 takes effect.
- R7: A seconds write loads the seconds counter, zeroes the milliseconds counter and the accumulator, and is visible at once at 0x008 and 0x010.
- R8: Seconds alarm 0 (0x014) sets event bit 0 and seconds alarm 1 (0x018) sets event bit 1. Each fires when the seconds counter becomes equal to its value, whether it got there by counting or by being written. An alarm value of 0 never fires.
- R9: The milliseconds alarm (0x01C) sets event bit 2 when the milliseconds counter advances to its value. A value of 1000 or more never matches.
- R10: In the event register (0x02C), writing 1 to a bit clears it and writing 0 leaves it alone. Bits 3 and 4 (countdown events) always read 0. The enable register (0x028) holds 5 bits and reads them back.
- R11: `irq` is high exactly while some event bit is set whose enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-clock strobe per 32 kHz reference period |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, same cycle |
| irq | output | 1 | Level interrupt: some event bit is set and enabled |

## Verification
The checks assume that `ref_tick` pulses at most once per clock. They also assume that eight ticks always span more clocks than COPY_CYCLES, so one copy window ends before the next one can start. The bench either drives ticks on every clock, where windows are 4 busy cycles in every 8, or stops them completely. All ordinary register writes are issued with ticks stopped and after any window has closed. The one intended write inside a busy window is aimed at the first busy cycle, so it reaches a clock edge where busy is still 1.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int SEC_W    = 32;
    localparam int MS_W     = 10;
    localparam int ACC_W    = 17;
    localparam int EVT_W    = 5;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 32;
    localparam int NUM_SALM = 2;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_BUSY   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_SEC    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_SHADOW = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_MSEC   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_SALM0  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_SALM1  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_MALM   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h2C;

    // event bit positions, shared by the event and enable registers
    localparam int EV_SALM0 = 0;
    localparam int EV_SALM1 = 1;
    localparam int EV_MALM  = 2;
    localparam int EV_SCDN  = 3;
    localparam int EV_MCDN  = 4;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MS_W-1:0]  ms;
    } rtc_time_t;

    typedef struct packed {
        logic             carry;
        logic [ACC_W-1:0] acc;
    } frac_t;

    // add num to the accumulator and take den out when it overflows
    function automatic frac_t frac_advance(input logic [ACC_W-1:0] acc,
                                           input int unsigned num,
                                           input int unsigned den);
        frac_t          r;
        logic [ACC_W:0] sum;
        sum = {1'b0, acc} + (ACC_W+1)'(num);
        if (sum >= (ACC_W+1)'(den)) begin
            r.carry = 1'b1;
            r.acc   = ACC_W'(sum - (ACC_W+1)'(den));
        end else begin
            r.carry = 1'b0;
            r.acc   = sum[ACC_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_pkg::*;
#(
    parameter int unsigned REF_HZ     = 32768,
    parameter int unsigned MS_PER_SEC = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_sec,
    output rtc_time_t        now,
    output logic             sec_upd,
    output logic             ms_upd
);

    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    logic [ACC_W-1:0] acc_q;
    frac_t            step;

    always_comb step = frac_advance(acc_q, MS_PER_SEC, REF_HZ);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            now     <= '0;
            sec_upd <= 1'b0;
            ms_upd  <= 1'b0;
        end else if (load_en) begin
            acc_q   <= '0;
            now.sec <= load_sec;
            now.ms  <= '0;
            sec_upd <= 1'b1;
            ms_upd  <= 1'b0;
        end else begin
            sec_upd <= 1'b0;
            ms_upd  <= 1'b0;
            if (tick) begin
                acc_q <= step.acc;
                if (step.carry) begin
                    ms_upd <= 1'b1;
                    if (now.ms == MS_LAST) begin
                        now.ms  <= '0;
                        now.sec <= now.sec + 1'b1;
                        sec_upd <= 1'b1;
                    end else begin
                        now.ms <= now.ms + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rtc_xfer.sv
module rtc_xfer
    import rtc_pkg::*;
#(
    parameter int unsigned TICKS_PER_COPY = 8,
    parameter int unsigned COPY_CYCLES    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  rtc_time_t        now,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_sec,
    output logic             busy,
    output rtc_time_t        pub
);

    localparam int PH_W  = (TICKS_PER_COPY > 1) ? $clog2(TICKS_PER_COPY) : 1;
    localparam int WIN_W = $clog2(COPY_CYCLES + 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(TICKS_PER_COPY - 1);
    localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(COPY_CYCLES - 1);

    logic [PH_W-1:0]  phase_q;
    logic [WIN_W-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            win_q   <= '0;
            busy    <= 1'b0;
            pub     <= '0;
        end else begin
            if (tick)
                phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;

            if (!busy && tick && phase_q == PH_LAST) begin
                busy  <= 1'b1;
                win_q <= WIN_LOAD;
            end else if (busy) begin
                if (win_q == '0) begin
                    busy <= 1'b0;
                    pub  <= now;
                end else begin
                    win_q <= win_q - 1'b1;
                end
            end

            // the top only raises load_en while busy is 0
            if (load_en) begin
                pub.sec <= load_sec;
                pub.ms  <= '0;
            end
        end
    end

endmodule

// File: rtl/rtc_alarm_bank.sv
module rtc_alarm_bank
    import rtc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_SALM-1:0]            wr_salm,
    input  logic                           wr_malm,
    input  logic                           wr_mask,
    input  logic                           wr_stat,
    input  logic [DATA_W-1:0]              wdata,
    input  rtc_time_t                      now,
    input  logic                           sec_upd,
    input  logic                           ms_upd,
    output logic [NUM_SALM-1:0][SEC_W-1:0] salm,
    output logic [MS_W-1:0]                malm,
    output logic [EVT_W-1:0]               mask,
    output logic [EVT_W-1:0]               status,
    output logic                           irq
);

    logic [NUM_SALM-1:0] sec_hit;
    logic [EVT_W-1:0]    set_vec;
    logic [EVT_W-1:0]    clr_vec;

    for (genvar g = 0; g < NUM_SALM; g++) begin : g_salm
        always_ff @(posedge clk) begin
            if (rst)
                salm[g] <= '0;
            else if (wr_salm[g])
                salm[g] <= wdata[SEC_W-1:0];
        end
        assign sec_hit[g] = sec_upd && (salm[g] != '0) && (now.sec == salm[g]);
    end

    always_comb begin
        set_vec                    = '0;
        set_vec[NUM_SALM-1:0]      = sec_hit;
        set_vec[EV_MALM]           = ms_upd && (now.ms == malm);
        clr_vec                    = wr_stat ? wdata[EVT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            malm   <= '0;
            mask   <= '0;
            status <= '0;
        end else begin
            if (wr_malm) malm <= wdata[MS_W-1:0];
            if (wr_mask) mask <= wdata[EVT_W-1:0];
            status <= (status & ~clr_vec) | set_vec;
        end
    end

    assign irq = |(status & mask);

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int unsigned REF_HZ         = 32768,
    parameter int unsigned MS_PER_SEC     = 1000,
    parameter int unsigned TICKS_PER_COPY = 8,
    parameter int unsigned COPY_CYCLES    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    rtc_time_t                      live_time;
    rtc_time_t                      pub_time;
    logic                           busy;
    logic                           sec_upd;
    logic                           ms_upd;
    logic [SEC_W-1:0]               shadow_sec;
    logic [NUM_SALM-1:0][SEC_W-1:0] salm;
    logic [MS_W-1:0]                malm;
    logic [EVT_W-1:0]               mask;
    logic [EVT_W-1:0]               status;

    logic                wr_ok;
    logic                rd_ms;
    logic                wr_sec;
    logic [NUM_SALM-1:0] wr_salm;

    assign wr_ok      = bus_sel && bus_wr && !busy;
    assign rd_ms      = bus_sel && !bus_wr && (bus_addr == OFS_MSEC);
    assign wr_sec     = wr_ok && (bus_addr == OFS_SEC);
    assign wr_salm[0] = wr_ok && (bus_addr == OFS_SALM0);
    assign wr_salm[1] = wr_ok && (bus_addr == OFS_SALM1);

    rtc_timebase #(
        .REF_HZ     (REF_HZ),
        .MS_PER_SEC (MS_PER_SEC)
    ) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .tick     (ref_tick),
        .load_en  (wr_sec),
        .load_sec (bus_wdata[SEC_W-1:0]),
        .now      (live_time),
        .sec_upd  (sec_upd),
        .ms_upd   (ms_upd)
    );

    rtc_xfer #(
        .TICKS_PER_COPY (TICKS_PER_COPY),
        .COPY_CYCLES    (COPY_CYCLES)
    ) u_xfer (
        .clk      (clk),
        .rst      (rst),
        .tick     (ref_tick),
        .now      (live_time),
        .load_en  (wr_sec),
        .load_sec (bus_wdata[SEC_W-1:0]),
        .busy     (busy),
        .pub      (pub_time)
    );

    rtc_alarm_bank u_alarms (
        .clk     (clk),
        .rst     (rst),
        .wr_salm (wr_salm),
        .wr_malm (wr_ok && (bus_addr == OFS_MALM)),
        .wr_mask (wr_ok && (bus_addr == OFS_MASK)),
        .wr_stat (wr_ok && (bus_addr == OFS_STAT)),
        .wdata   (bus_wdata),
        .now     (live_time),
        .sec_upd (sec_upd),
        .ms_upd  (ms_upd),
        .salm    (salm),
        .malm    (malm),
        .mask    (mask),
        .status  (status),
        .irq     (irq)
    );

    // coherent pair: the milliseconds read freezes the visible seconds
    always_ff @(posedge clk) begin
        if (rst)
            shadow_sec <= '0;
        else if (rd_ms)
            shadow_sec <= pub_time.sec;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_BUSY:   bus_rdata[0]         = busy;
            OFS_SEC:    bus_rdata[SEC_W-1:0] = pub_time.sec;
            OFS_SHADOW: bus_rdata[SEC_W-1:0] = shadow_sec;
            OFS_MSEC:   bus_rdata[MS_W-1:0]  = pub_time.ms;
            OFS_SALM0:  bus_rdata[SEC_W-1:0] = salm[0];
            OFS_SALM1:  bus_rdata[SEC_W-1:0] = salm[1];
            OFS_MALM:   bus_rdata[MS_W-1:0]  = malm;
            OFS_MASK:   bus_rdata[EVT_W-1:0] = mask;
            OFS_STAT:   bus_rdata[EVT_W-1:0] = status;
            default:    bus_rdata            = '0;
        endcase
    end

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
    import rtc_pkg::*;
#(
    parameter int unsigned COPY_CYCLES = 4,
    parameter int unsigned MS_PER_SEC  = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              busy,
    input logic [SEC_W-1:0]  pub_sec,
    input logic [SEC_W-1:0]  shadow_sec,
    input logic [MS_W-1:0]   live_ms,
    input logic [SEC_W-1:0]  salm0,
    input logic [EVT_W-1:0]  status,
    input logic              sec_upd,
    input logic              irq
);

    logic [31:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_run == COPY_CYCLES);

    p_shadow_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == OFS_MSEC) |=> shadow_sec == $past(pub_sec));

    p_ms_range_r4: assert property (@(posedge clk) disable iff (rst)
        live_ms < MS_W'(MS_PER_SEC));

    p_busy_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && busy && bus_addr == OFS_SALM0) |=> $stable(salm0));

    p_alarm_off_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(status[EV_SALM0]) |-> $past(salm0) != '0);

    p_w1c_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !busy && bus_addr == OFS_STAT
         && bus_wdata[EV_SALM0] && !sec_upd) |=> !status[EV_SALM0]);

    p_cdn_zero_r10: assert property (@(posedge clk) disable iff (rst)
        status[EV_MCDN:EV_SCDN] == 2'b00);

    p_irq_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (irq && !(bus_sel && bus_wr && !busy)) |=> irq);

endmodule

bind rtc_core rtc_core_chk #(
    .COPY_CYCLES (COPY_CYCLES),
    .MS_PER_SEC  (MS_PER_SEC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .pub_sec    (pub_time.sec),
    .shadow_sec (shadow_sec),
    .live_ms    (live_time.ms),
    .salm0      (salm[0]),
    .status     (status),
    .sec_upd    (sec_upd),
    .irq        (irq)
);

// File: tb/tb_rtc_core.sv
`timescale 1ns/1ps
module tb_rtc_core;
    import rtc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ref_tick = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    rtc_core dut (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: compares read data against the queued expectation
    always @(negedge clk) begin
        if (bus_sel && !bus_wr && sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (bus_rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s: read got 0x%08h expected 0x%08h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
        @(posedge clk); #1;
        sb_q.push_back('{exp: e, tag: tag});
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = a;
        @(posedge clk); #1;
        bus_sel  = 1'b0;
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(posedge clk); #1;
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk); #1;
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    // n ticks on consecutive clocks, then idle long enough to close any window
    task automatic run_ticks(input int n);
        @(posedge clk); #1;
        ref_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        ref_tick = 1'b0;
        repeat (8) @(posedge clk);
    endtask

    task automatic check_irq(input logic e, input string tag);
        @(negedge clk);
        check(irq === e, tag, int'(irq), int'(e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int busy_cnt;
        logic prev_b;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check_irq(1'b0, "R1 irq after reset");
        bus_read(OFS_BUSY,   0, "R1 busy");
        bus_read(OFS_SEC,    0, "R1 seconds");
        bus_read(OFS_SHADOW, 0, "R1 shadow");
        bus_read(OFS_MSEC,   0, "R1 msec");
        bus_read(OFS_SALM0,  0, "R1 alarm0");
        bus_read(OFS_SALM1,  0, "R1 alarm1");
        bus_read(OFS_MALM,   0, "R1 ms alarm");
        bus_read(OFS_MASK,   0, "R1 mask");
        bus_read(OFS_STAT,   0, "R1 status");

        // R7 seconds load, R3 shadow capture
        bus_write(OFS_SEC, 100);
        bus_read(OFS_SEC,    100, "R7 seconds load");
        bus_read(OFS_SHADOW, 0,   "R3 shadow before ms read");
        bus_read(OFS_MSEC,   0,   "R7 ms zeroed");
        bus_read(OFS_SHADOW, 100, "R3 shadow after ms read");

        // R4 fractional rate: 328 ticks -> 10 ms
        run_ticks(328);
        bus_read(OFS_MSEC, 10,  "R4 ms after 328 ticks");
        bus_read(OFS_SEC,  100, "R4 seconds unchanged");

        // R9 ms alarm: 456 ticks -> 13, 488 -> 14, 496 -> 15
        bus_write(OFS_MALM, 15);
        run_ticks(128);
        run_ticks(32);
        bus_read(OFS_MSEC, 14, "R4 ms at 14");
        bus_read(OFS_STAT, 0,  "R9 no match yet");
        run_ticks(8);
        bus_read(OFS_MSEC, 15, "R4 ms at 15");
        bus_read(OFS_STAT, 4,  "R9 ms alarm bit2");
        check_irq(1'b0, "R11 masked event");

        // R10 / R11 enable and write-one-to-clear
        bus_write(OFS_MASK, 4);
        check_irq(1'b1, "R11 enabled event");
        bus_write(OFS_STAT, 0);
        bus_read(OFS_STAT, 4, "R10 write 0 keeps bit");
        bus_write(OFS_STAT, 32'h1F);
        bus_read(OFS_STAT, 0, "R10 write 1 clears");
        check_irq(1'b0, "R11 irq drops on clear");
        bus_write(OFS_MASK, 32'hFFFF_FFFF);
        bus_read(OFS_MASK, 32'h1F, "R10 mask 5 bits");
        bus_write(OFS_MALM, 1000);
        bus_read(OFS_MALM, 1000, "R9 ms alarm readback");

        // R5 wrap, R8 counting alarm
        bus_write(OFS_MASK, 1);
        bus_write(OFS_SEC, 7);
        bus_write(OFS_SALM0, 8);
        run_ticks(32768);
        bus_read(OFS_SEC,  8, "R5 seconds increment");
        bus_read(OFS_MSEC, 0, "R5 ms wrapped");
        bus_read(OFS_STAT, 1, "R8 alarm0 by counting, R9 1000 never matches");
        check_irq(1'b1, "R11 alarm0 enabled");
        bus_write(OFS_STAT, 32'h1F);

        // R8 zero disables, written match fires
        bus_write(OFS_SEC, 0);
        bus_read(OFS_STAT, 0, "R8 alarm value 0 disabled");
        bus_write(OFS_SALM1, 50);
        bus_write(OFS_SEC, 50);
        bus_read(OFS_STAT, 2, "R8 alarm1 by write");
        check_irq(1'b0, "R11 alarm1 not enabled");
        bus_write(OFS_MASK, 2);
        check_irq(1'b1, "R11 alarm1 enabled");
        bus_write(OFS_STAT, 32'h1F);
        bus_write(OFS_MASK, 0);

        // R2 transfer only at end of window: 32 ticks -> ms 0, 36 -> live 1
        bus_write(OFS_SEC, 200);
        run_ticks(32);
        run_ticks(4);
        bus_read(OFS_MSEC, 0, "R2 not transferred mid-phase");
        run_ticks(4);
        bus_read(OFS_MSEC, 1, "R2 transferred after eighth tick");

        // R2 busy duty, R6 write in busy window dropped
        @(posedge clk); #1;
        ref_tick = 1'b1;
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = OFS_BUSY;
        repeat (16) @(posedge clk);
        busy_cnt = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (bus_rdata[0]) busy_cnt++;
        end
        check(busy_cnt == 32, "R2 busy cycles in 64", busy_cnt, 32);
        @(negedge clk);
        prev_b = bus_rdata[0];
        forever begin
            @(negedge clk);
            if (bus_rdata[0] && !prev_b) break;
            prev_b = bus_rdata[0];
        end
        bus_wr    = 1'b1;
        bus_addr  = OFS_SALM0;
        bus_wdata = 32'h55;
        @(posedge clk); #1;
        bus_sel  = 1'b0;
        bus_wr   = 1'b0;
        ref_tick = 1'b0;
        repeat (10) @(posedge clk);
        bus_read(OFS_SALM0, 8, "R6 write while busy ignored");
        bus_write(OFS_SALM0, 32'h55);
        bus_read(OFS_SALM0, 32'h55, "R6 write while idle taken");

        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule